// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block sits between a memory-mapped host port and a configuration request bus. The host sees two windows of 4 KiB each; the window decode is done upstream, and the block receives a window select and the three low offset bits. A write to the index window stores a 32-bit configuration index. Any read or write to the data window starts one configuration transaction downstream. That transaction carries a translated address, byte enables, lane-aligned write data and a direction flag.

The outgoing address is built from the stored index and the low offset bits in one of three formats. Index bit 31 wins over bit 0. In the first format the index is passed through and the low offset bits are merged in. In the second format the index is kept above bit 3. In the third format a one-hot device select in the high index bits is turned into a slot number by a lowest-set-bit encoder. When that third format finds no select bit, the access completes locally and no transaction is sent. The host access is stalled until the result is ready, and only one downstream transaction is ever in flight.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset the stored index is zero, `h_ready` is low and `d_req` is low.
- R2: An index-window write stores the full `h_wdata` word, whatever `h_size` is. An index-window read returns the stored word. Either access completes with a one-cycle `h_ready` pulse in the cycle after the request is sampled.
- R3: If index bit 31 is 1, `d_addr` equals the index with `h_off[1:0]` ORed into its bits 1:0.
- R4: If index bit 31 is 0 and bit 0 is 1, `d_addr` is index bits 31:3 followed by `h_off[2:0]`.
- R5: If index bits 31 and 0 are both 0, `d_addr[15:11]` is the position, counted from bit 11, of the lowest 1 among index bits 31:11. `d_addr[10:3]` equals index bits 10:3, `d_addr[2:0]` equals `h_off[2:0]`, and the upper bits are 0.
- R6: In the format of R5, if index bits 31:11 are all 0, no downstream request is made and the access completes one cycle after the request. A read then returns 0xFFFFFFFF.
- R7: `h_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The lane shift is `h_off[1:0]` for a byte, `h_off[1:0]` with bit 0 cleared for two bytes, and 0 for four bytes. `d_be` is the size mask shifted by that lane shift, and `d_wdata` is the low `h_size` bytes of `h_wdata` shifted left by eight times the lane shift.
- R8: Read data from `d_rdata` is shifted right by eight times the lane shift and zero-extended above the access size before it is returned on `h_rdata`.
- R9: `d_req` rises one cycle after a valid data-window request is sampled. It stays high with stable `d_addr`, `d_be`, `d_we` and `d_wdata` until `d_rsp` is sampled, and it is low in the next cycle. `h_ready` pulses in that next cycle.
- R10: When index bits 31 and 0 are both 1, the format of R3 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_win | input | 1 | 0 selects the index window, 1 selects the data window |
| h_we | input | 1 | Host write when 1, read when 0 |
| h_off | input | 3 | Low bits of the offset within the window |
| h_size | input | 2 | Access size code (see R7) |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_rdata | output | 32 | Host read data, right-aligned |
| h_ready | output | 1 | One-cycle completion pulse |
| d_req | output | 1 | Downstream transaction valid |
| d_we | output | 1 | Downstream write when 1 |
| d_addr | output | 32 | Translated configuration address |
| d_be | output | 4 | Byte enables |
| d_wdata | output | 32 | Lane-aligned write data |
| d_rsp | input | 1 | Downstream response valid, completes the transaction |
| d_rdata | input | 32 | Downstream read data, lane-aligned |

## Verification
Index-window accesses and dropped translations must raise `h_ready` exactly one cycle after the request edge. A data-window access raises `d_req` one cycle after the request edge and raises `h_ready` one cycle after the edge that samples `d_rsp`, so an access answered at once takes two cycles. Inputs are driven on falling edges and outputs are sampled on falling edges. For each access the bench counts falling edges from the request until `h_ready` and compares that count with 1 or 2 plus the response delay it chose. It also captures the downstream fields on the first falling edge that shows `d_req` and compares them on every later edge while the response is withheld.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      XM_PASS  = 2'd0,
      XM_TYPE1 = 2'd1,
      XM_TYPE0 = 2'd2
   } xmode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } state_e;

endpackage

// File: rtl/cfgx_lsb_enc.sv
module cfgx_lsb_enc #(
   parameter int W = 21,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] pos,
   output logic          found
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cfgx_lsb_enc: W must be at least 1");
      end
   endgenerate

   // scan downwards so the lowest set bit is the last one to win
   always_comb begin
      pos   = '0;
      found = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            pos   = IW'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
   import cfgx_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SLOT_LO = 11,
   parameter int SLOT_W  = 5,
   localparam int VEC_W  = AW - SLOT_LO,
   localparam int PW     = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] idx,
   input  logic [2:0]    off,
   output logic [AW-1:0] addr,
   output xmode_e        mode,
   output logic          ok
);

   generate
      if (SLOT_W < PW) begin : g_bad_slot
         $error("cfgx_xlate: SLOT_W too narrow for the select field");
      end
      if (SLOT_LO + SLOT_W > AW || SLOT_LO < 4) begin : g_bad_lo
         $error("cfgx_xlate: slot field does not fit the address");
      end
   endgenerate

   logic [PW-1:0] slot_pos;
   logic          slot_found;

   cfgx_lsb_enc #(.W(VEC_W)) u_enc (
      .vec   (idx[AW-1:SLOT_LO]),
      .pos   (slot_pos),
      .found (slot_found)
   );

   always_comb begin
      addr = '0;
      if (idx[AW-1]) begin
         mode = XM_PASS;
         ok   = 1'b1;
         addr = idx | AW'(off[1:0]);
      end else if (idx[0]) begin
         mode = XM_TYPE1;
         ok   = 1'b1;
         addr = {idx[AW-1:3], off};
      end else begin
         mode = XM_TYPE0;
         ok   = slot_found;
         addr[SLOT_LO +: SLOT_W] = SLOT_W'(slot_pos);
         addr[SLOT_LO-1:3]       = idx[SLOT_LO-1:3];
         addr[2:0]               = off;
      end
   end

   // R5: the encoder result points at a set bit with nothing set below it
   p_slot_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XM_TYPE0 && ok) |->
         (idx[SLOT_LO + 32'(slot_pos)] &&
          ((idx[AW-1:SLOT_LO] & ((VEC_W'(1) << slot_pos) - VEC_W'(1))) == '0)));

   // R6: a type-0 index with no select bit never reports a usable translation
   p_empty_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx[AW-1] && !idx[0] && idx[AW-1:SLOT_LO] == '0) |-> !ok);

endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes #(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic [1:0]    size,
   input  logic [LW-1:0] lane,
   input  logic [DW-1:0] wdata_in,
   input  logic [DW-1:0] rdata_in,
   output logic [NB-1:0] be,
   output logic [DW-1:0] wdata_out,
   output logic [DW-1:0] rdata_out
);

   generate
      if (DW % 8 != 0 || NB < 4) begin : g_bad_dw
         $error("cfgx_lanes: DW must be a multiple of 8 and at least 32");
      end
   endgenerate

   logic [NB-1:0] bmask;
   logic [LW-1:0] shift;
   logic [DW-1:0] bits;

   always_comb begin
      case (size)
         2'd0: begin
            bmask = NB'(1);
            shift = lane;
         end
         2'd1: begin
            bmask = NB'(3);
            shift = lane & ~LW'(1);
         end
         default: begin
            bmask = '1;
            shift = '0;
         end
      endcase
   end

   for (genvar g = 0; g < NB; g++) begin : g_bits
      assign bits[8*g +: 8] = {8{bmask[g]}};
   end

   assign be        = bmask << shift;
   assign wdata_out = (wdata_in & bits) << {shift, 3'b000};
   assign rdata_out = (rdata_in >> {shift, 3'b000}) & bits;

endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
   import cfgx_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int SLOT_LO = 11,
   parameter int SLOT_W  = 5,
   localparam int NB     = DW / 8,
   localparam int LW     = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_req,
   input  logic          h_win,
   input  logic          h_we,
   input  logic [2:0]    h_off,
   input  logic [1:0]    h_size,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   output logic          h_ready,
   output logic          d_req,
   output logic          d_we,
   output logic [AW-1:0] d_addr,
   output logic [NB-1:0] d_be,
   output logic [DW-1:0] d_wdata,
   input  logic          d_rsp,
   input  logic [DW-1:0] d_rdata
);

   generate
      if (LW > 3) begin : g_bad_lanes
         $error("cfgx_bridge: lane index exceeds the offset input");
      end
      if (DW != AW) begin : g_bad_idx
         $error("cfgx_bridge: the index is written through the data port");
      end
   endgenerate

   state_e        state;
   logic [AW-1:0] idx_q;
   logic [DW-1:0] rd_q;
   logic [LW-1:0] lane_q;
   logic [1:0]    size_q;

   logic [AW-1:0] x_addr;
   xmode_e        x_mode;
   logic          x_ok;
   logic [1:0]    sz_sel;
   logic [LW-1:0] lane_sel;
   logic [NB-1:0] l_be;
   logic [DW-1:0] l_wdata;
   logic [DW-1:0] l_rdata;

   cfgx_xlate #(.AW(AW), .SLOT_LO(SLOT_LO), .SLOT_W(SLOT_W)) u_xlate (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (idx_q),
      .off   (h_off),
      .addr  (x_addr),
      .mode  (x_mode),
      .ok    (x_ok)
   );

   // the lane unit serves both the issue edge and the response edge
   assign sz_sel   = (state == ST_IDLE) ? h_size : size_q;
   assign lane_sel = (state == ST_IDLE) ? h_off[LW-1:0] : lane_q;

   cfgx_lanes #(.DW(DW)) u_lanes (
      .size      (sz_sel),
      .lane      (lane_sel),
      .wdata_in  (h_wdata),
      .rdata_in  (d_rdata),
      .be        (l_be),
      .wdata_out (l_wdata),
      .rdata_out (l_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx_q   <= '0;
         rd_q    <= '0;
         lane_q  <= '0;
         size_q  <= '0;
         d_req   <= 1'b0;
         d_we    <= 1'b0;
         d_addr  <= '0;
         d_be    <= '0;
         d_wdata <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (h_req) begin
                  if (!h_win) begin
                     if (h_we) idx_q <= h_wdata;
                     rd_q  <= idx_q;
                     state <= ST_DONE;
                  end else if (x_ok) begin
                     d_req   <= 1'b1;
                     d_we    <= h_we;
                     d_addr  <= x_addr;
                     d_be    <= l_be;
                     d_wdata <= l_wdata;
                     lane_q  <= h_off[LW-1:0];
                     size_q  <= h_size;
                     state   <= ST_BUSY;
                  end else begin
                     rd_q  <= '1;
                     state <= ST_DONE;
                  end
               end
            end
            ST_BUSY: begin
               if (d_rsp) begin
                  d_req <= 1'b0;
                  rd_q  <= d_we ? '0 : l_rdata;
                  state <= ST_DONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign h_ready = (state == ST_DONE);
   assign h_rdata = rd_q;

   // R9: request and its fields hold until the response is sampled
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && !d_rsp) |=> (d_req && $stable(d_addr) && $stable(d_be) &&
                             $stable(d_wdata) && $stable(d_we)));

   // R9: a sampled response retires the request and completes the host access
   p_ready_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && d_rsp) |=> (h_ready && !d_req));

   // R9: never a completion while a transaction is still open
   p_single_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |-> !d_req);

   // R2: completion is a single-cycle pulse
   p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready);

   // R7: an open request enables one, two or all byte lanes
   p_be_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      d_req |-> ($countones(d_be) == 1 || $countones(d_be) == 2 ||
                 $countones(d_be) == NB));

endmodule

// File: tb/test_cfgx_bridge.sv
`timescale 1ns/100ps
module test_cfgx_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0, h_win = 1'b0, h_we = 1'b0;
   logic [2:0]  h_off = '0;
   logic [1:0]  h_size = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_ready;
   logic        d_req, d_we;
   logic [31:0] d_addr;
   logic [3:0]  d_be;
   logic [31:0] d_wdata;
   logic        d_rsp = 1'b0;
   logic [31:0] d_rdata = '0;

   int n_cmp = 0;
   int n_mis = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cfgx_bridge i_cfgx_bridge (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_win(h_win), .h_we(h_we),
      .h_off(h_off), .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .h_ready(h_ready), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
      .d_be(d_be), .d_wdata(d_wdata), .d_rsp(d_rsp), .d_rdata(d_rdata)
   );

   typedef struct packed {
      logic [31:0] idx;
      logic [2:0]  off;
      logic [1:0]  size;
      logic        we;
      logic [31:0] wdata;
      logic        issue;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] dwd;
      logic [31:0] rsp;
      logic [31:0] hrd;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R5 slot 0, function 0, word read
      '{32'h0000_0814, 3'd0, 2'd2, 1'b0, 32'h0, 1'b1, 32'h0000_0010, 4'hF, 32'h0, 32'hAABB_CCDD, 32'hAABB_CCDD, 8'd5},
      // R5 two select bits, lowest wins; byte read lane 2 (R8)
      '{32'h0003_0548, 3'd2, 2'd0, 1'b0, 32'h0, 1'b1, 32'h0000_2D4A, 4'h4, 32'h0, 32'h1122_3344, 32'h0000_0022, 8'd5},
      // R5 slot 19; half write upper lanes (R7)
      '{32'h4000_0208, 3'd6, 2'd1, 1'b1, 32'hDEAD_BEEF, 1'b1, 32'h0000_9A0E, 4'hC, 32'hBEEF_0000, 32'h0, 32'h0, 8'd7},
      // R4 type-1 byte write lane 1
      '{32'h0012_3457, 3'd5, 2'd0, 1'b1, 32'h1234_565A, 1'b1, 32'h0012_3455, 4'h2, 32'h0000_5A00, 32'h0, 32'h0, 8'd4},
      // R3 pass-through byte read lane 3
      '{32'h8000_0104, 3'd3, 2'd0, 1'b0, 32'h0, 1'b1, 32'h8000_0107, 4'h8, 32'h0, 32'h9988_7766, 32'h0000_0099, 8'd3},
      // R10 bits 31 and 0 both set: pass-through wins
      '{32'h8000_0A01, 3'd6, 2'd2, 1'b0, 32'h0, 1'b1, 32'h8000_0A03, 4'hF, 32'h0, 32'h0102_0304, 32'h0102_0304, 8'd10},
      // R6 empty select, read returns all ones
      '{32'h0000_07F8, 3'd0, 2'd2, 1'b0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 8'd6},
      // R6 empty select, write dropped
      '{32'h0000_0000, 3'd1, 2'd0, 1'b1, 32'h0000_00AA, 1'b0, 32'h0, 4'h0, 32'h0, 32'h0, 32'h0, 8'd6},
      // R8 half read with odd offset uses lanes 1:0
      '{32'h0000_1001, 3'd1, 2'd1, 1'b0, 32'h0, 1'b1, 32'h0000_1001, 4'h3, 32'h0, 32'hCAFE_F00D, 32'h0000_F00D, 8'd8},
      // R7 word write, type-0 slot 1 function 3
      '{32'h0000_1340, 3'd4, 2'd2, 1'b1, 32'h1357_9BDF, 1'b1, 32'h0000_0B44, 4'hF, 32'h1357_9BDF, 32'h0, 32'h0, 8'd7}
   };

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
      end
   endtask

   task automatic access(input logic win, input logic we, input logic [2:0] off,
                         input logic [1:0] size, input logic [31:0] wdata,
                         input int delay, input logic [31:0] rsp_data,
                         output logic [31:0] rdata, output logic issued,
                         output logic [31:0] a, output logic [3:0] be,
                         output logic [31:0] wd, output logic w,
                         output int lat, output logic held_ok);
      int waited;
      waited  = 0;
      issued  = 1'b0;
      held_ok = 1'b1;
      lat     = 0;
      a = '0; be = '0; wd = '0; w = 1'b0;
      @(negedge clk);
      h_req = 1'b1; h_win = win; h_we = we; h_off = off; h_size = size; h_wdata = wdata;
      forever begin
         @(negedge clk);
         lat++;
         if (h_ready) begin
            if (d_req) held_ok = 1'b0;
            break;
         end
         if (lat > 50) break;
         if (d_req) begin
            if (!issued) begin
               issued = 1'b1;
               a = d_addr; be = d_be; wd = d_wdata; w = d_we;
            end else if (d_addr !== a || d_be !== be || d_wdata !== wd || d_we !== w) begin
               held_ok = 1'b0;
            end
            if (waited >= delay) begin
               d_rsp   = 1'b1;
               d_rdata = rsp_data;
            end else begin
               waited++;
            end
         end
      end
      rdata = h_rdata;
      h_req = 1'b0;
      d_rsp = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_mis++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, a, wd;
      logic [3:0]  be;
      logic        iss, w, held;
      int          lat;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 h_ready", {31'b0, h_ready}, 32'h0);
      chk("R1 d_req", {31'b0, d_req}, 32'h0);
      rst_n = 1'b1;
      access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R1 index after reset", rd, 32'h0);

      // R2 index write with byte size still stores the full word, then read back
      access(1'b0, 1'b1, 3'd5, 2'd0, 32'h89AB_CDEF, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R2 write latency", 32'(lat), 32'd1);
      chk("R2 write no downstream", {31'b0, iss}, 32'h0);
      access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R2 readback", rd, 32'h89AB_CDEF);
      chk("R2 read latency", 32'(lat), 32'd1);

      // vector table: program the index, then one data-window access
      for (int k = 0; k < NV; k++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[k].rq, k);
         access(1'b0, 1'b1, 3'd0, 2'd2, VECS[k].idx, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
         access(1'b1, VECS[k].we, VECS[k].off, VECS[k].size, VECS[k].wdata, 0, VECS[k].rsp,
                rd, iss, a, be, wd, w, lat, held);
         chk({tag, " issued"}, {31'b0, iss}, {31'b0, VECS[k].issue});
         chk({tag, " latency"}, 32'(lat), VECS[k].issue ? 32'd2 : 32'd1);
         if (VECS[k].issue) begin
            chk({tag, " addr"}, a, VECS[k].addr);
            chk({tag, " be"}, {28'b0, be}, {28'b0, VECS[k].be});
            chk({tag, " dir"}, {31'b0, w}, {31'b0, VECS[k].we});
            if (VECS[k].we) chk({tag, " wdata"}, wd, VECS[k].dwd);
         end
         if (!VECS[k].we) chk({tag, " rdata"}, rd, VECS[k].hrd);
      end

      // R9 withheld response: request holds, completion follows the response
      access(1'b0, 1'b1, 3'd0, 2'd2, 32'h0001_0300, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      access(1'b1, 1'b0, 3'd2, 2'd1, 32'h0, 3, 32'h5566_7788, rd, iss, a, be, wd, w, lat, held);
      chk("R9 delayed latency", 32'(lat), 32'd5);
      chk("R9 fields held", {31'b0, held}, 32'h1);
      chk("R5 slot 5 addr", a, 32'h0000_2B02);
      chk("R8 half upper lanes", rd, 32'h0000_5566);

      // R6 write dropped: index left untouched, readback unchanged
      access(1'b0, 1'b1, 3'd0, 2'd2, 32'h0000_0010, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      access(1'b1, 1'b1, 3'd0, 2'd2, 32'hFFFF_0000, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R6 dropped write no request", {31'b0, iss}, 32'h0);
      access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R6 index unchanged", rd, 32'h0000_0010);

      // R1 reset in mid-life clears the index again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      access(1'b0, 1'b0, 3'd0, 2'd2, 32'h0, 0, 32'h0, rd, iss, a, be, wd, w, lat, held);
      chk("R1 index cleared", rd, 32'h0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

endmodule